// File: doc/BRIEF.md
# Multi-format multiply-accumulate unit

This block is a sequential arithmetic engine with a 64-bit accumulator. Each job takes a first operand that is either a 32-bit word or a full 64-bit value, and a 32-bit second operand. It can form a plain product or a product added to the accumulator. In a third shape, the accumulator is multiplied by the second operand and a 64-bit addend is added. Whatever the shape, the outcome is written back into the accumulator.

Operands are read in one of three number formats: unsigned integer, two's-complement integer, or signed fraction. A fraction is Q0.31 for a 32-bit word and Q0.63 for the accumulator or a 64-bit operand. Every job runs either wrapping or saturating. On completion the unit updates three flags: a sticky product-overflow flag, a sticky accumulation-overflow flag and a sign flag.

A host raises `start_i` for one cycle with the job fields and operands, while the unit is idle. The product is built 32 bits of the multiplicand per cycle. One cycle later the accumulator and flags change together with a one-cycle `done_o` pulse.

Top module: `fmac_unit`

## Requirements
- R1: After reset, `acc_o` is zero, the three flags are 0, and `done_o` and `busy_o` are 0.
- R2: `fmt_i` selects the number format: 0 unsigned, 1 signed integer, 2 signed fraction, 3 signed integer. `form_i` selects the job: 0 P=W·B, 1 P=D·B, 2 P=ACC·B, 3 ACC=W·B+ACC, 4 ACC=D·B+ACC, 5 ACC=ACC·B+D. Here W is `op_a_i[31:0]`, D is the whole of `op_a_i`, and B is `op_b_i`. Every result is written into the accumulator.
- R3: In the integer formats the exact product is checked against the 64-bit range of the format. If it does not fit, the product-overflow flag is set. It is then clamped to the nearest range limit when `sat_i` is 1, and truncated to its low 64 bits otherwise.
- R4: In fraction format a 32-bit W is read as the upper half of a Q0.63 value. The exact product is shifted right by 31 bits, arithmetic shift with truncation. This makes W·B equal to the Q0.62 product shifted left by one. Hence −1·−1 does not fit and sets product overflow. It gives 0x7FFF_FFFF_FFFF_FFFF when saturating and 0x8000_0000_0000_0000 when wrapping.
- R5: In forms 3 to 5 the possibly clamped product is added to the addend. If the 64-bit sum overflows the format's range, the accumulation-overflow flag is set. The sum is then clamped when `sat_i` is 1 and wrapped otherwise. Forms 0 to 2 leave that flag unchanged.
- R6: On every completion, `flag_n_o` takes bit 63 of the new accumulator in the signed formats and 0 in unsigned format.
- R7: Product overflow and accumulation overflow are sticky. A cycle with `clr_flags_i` high clears both. If a completion in that same cycle raises a flag, that flag ends up set.
- R8: Starting from the rising edge that accepts `start_i`, `busy_o` is high for three cycles. The new accumulator and flags appear with `done_o`, which is sampled high at the fourth rising edge after acceptance and lasts exactly one cycle.
- R9: `start_i` is ignored while `busy_o` is high. It neither changes the running job nor queues a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a job when idle |
| fmt_i | input | 2 | Number format |
| form_i | input | 3 | Job shape |
| sat_i | input | 1 | 1 saturates, 0 wraps |
| op_a_i | input | 64 | First operand (W is its low word) |
| op_b_i | input | 32 | Second operand |
| clr_flags_i | input | 1 | Clear both sticky overflow flags |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| acc_o | output | 64 | Accumulator |
| flag_v_o | output | 1 | Sticky product overflow |
| flag_q_o | output | 1 | Sticky accumulation overflow |
| flag_n_o | output | 1 | Sign of the last result |

## Verification
The function most at risk of colliding with another is the software-side flag clear. It can fall in the very cycle in which a finishing job merges its new overflow events into the sticky flags. The bench raises `clr_flags_i` so that it is sampled exactly at the completing edge. It does this once with a job that overflows and once with a job that does not. It expects the flag to survive in the first case and be cleared in the second. A second overlap is a fresh `start_i` held high with different operands while a job is busy. That is judged by the result still matching the first job and by `busy_o` staying low after `done_o`.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
    typedef enum logic [1:0] {
        FMT_UNS = 2'd0,
        FMT_SGN = 2'd1,
        FMT_FRC = 2'd2,
        FMT_SG2 = 2'd3
    } fmt_e;

    typedef enum logic [2:0] {
        FORM_MUL_W = 3'd0,
        FORM_MUL_D = 3'd1,
        FORM_MUL_A = 3'd2,
        FORM_MAC_W = 3'd3,
        FORM_MAC_D = 3'd4,
        FORM_MAC_A = 3'd5
    } form_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_FIN  = 2'd3
    } state_e;
endpackage

// File: rtl/fmac_opsel.sv
module fmac_opsel
    import fmac_pkg::*;
#(
    parameter int unsigned HALF_W = 32
) (
    input  logic [1:0]          fmt_i,
    input  logic [2:0]          form_i,
    input  logic [2*HALF_W-1:0] op_a_i,
    input  logic [2*HALF_W-1:0] acc_i,
    output logic [2*HALF_W-1:0] mcand_o,
    output logic [2*HALF_W-1:0] addend_o,
    output logic                add_en_o,
    output logic                is_signed_o,
    output logic                is_frac_o
);
    localparam int unsigned FULL_W = 2 * HALF_W;

    logic [HALF_W-1:0] word;
    logic [FULL_W-1:0] word_ext;

    always_comb begin
        is_signed_o = (fmt_i != FMT_UNS);
        is_frac_o   = (fmt_i == FMT_FRC);
        word        = op_a_i[HALF_W-1:0];
        if (is_frac_o) begin
            word_ext = {word, {HALF_W{1'b0}}};
        end else if (is_signed_o) begin
            word_ext = {{HALF_W{word[HALF_W-1]}}, word};
        end else begin
            word_ext = {{HALF_W{1'b0}}, word};
        end

        case (form_i)
            FORM_MUL_D, FORM_MAC_D: mcand_o = op_a_i;
            FORM_MUL_A, FORM_MAC_A: mcand_o = acc_i;
            default:                mcand_o = word_ext;
        endcase

        add_en_o = (form_i == FORM_MAC_W) || (form_i == FORM_MAC_D) ||
                   (form_i == FORM_MAC_A);
        addend_o = (form_i == FORM_MAC_A) ? op_a_i : acc_i;
    end
endmodule

// File: rtl/fmac_mul_iter.sv
module fmac_mul_iter #(
    parameter int unsigned HALF_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [2*HALF_W-1:0]   mcand_i,
    input  logic                  is_signed_i,
    input  logic [HALF_W-1:0]     mult_i,
    input  logic                  step_lo_i,
    input  logic                  step_hi_i,
    output logic [3*HALF_W+1:0]   product_o
);
    localparam int unsigned FULL_W = 2 * HALF_W;
    localparam int unsigned PP_W   = 2 * HALF_W + 2;
    localparam int unsigned PROD_W = 3 * HALF_W + 2;

    typedef struct packed {
        logic [FULL_W-1:0] m;
        logic              s;
        logic [HALF_W:0]   b;
        logic [PP_W-1:0]   part;
        logic [PROD_W-1:0] prod;
    } mul_t;

    mul_t mul_d, mul_q;
    logic signed [PP_W-1:0] lo_pp;
    logic signed [PP_W-1:0] hi_pp;

    always_comb begin
        mul_d = mul_q;
        // low half of the multiplicand is always an unsigned digit
        lo_pp = $signed({1'b0, mul_q.m[HALF_W-1:0]}) * $signed(mul_q.b);
        hi_pp = $signed({mul_q.s & mul_q.m[FULL_W-1], mul_q.m[FULL_W-1:HALF_W]})
                * $signed(mul_q.b);
        if (load_i) begin
            mul_d.m = mcand_i;
            mul_d.s = is_signed_i;
            mul_d.b = {is_signed_i & mult_i[HALF_W-1], mult_i};
        end
        if (step_lo_i) begin
            mul_d.part = lo_pp;
        end
        if (step_hi_i) begin
            mul_d.prod = ({{HALF_W{hi_pp[PP_W-1]}}, hi_pp} << HALF_W)
                       + {{(PROD_W-PP_W){mul_q.part[PP_W-1]}}, mul_q.part};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mul_q <= '0;
        end else begin
            mul_q <= mul_d;
        end
    end

    assign product_o = mul_q.prod;
endmodule

// File: rtl/fmac_finish.sv
module fmac_finish #(
    parameter int unsigned HALF_W = 32
) (
    input  logic [3*HALF_W+1:0]  product_i,
    input  logic                 is_signed_i,
    input  logic                 is_frac_i,
    input  logic                 sat_i,
    input  logic                 add_en_i,
    input  logic [2*HALF_W-1:0]  addend_i,
    output logic [2*HALF_W-1:0]  result_o,
    output logic                 ovf_mul_o,
    output logic                 ovf_add_o,
    output logic                 neg_o
);
    localparam int unsigned FULL_W = 2 * HALF_W;
    localparam int unsigned PROD_W = 3 * HALF_W + 2;

    logic signed [PROD_W-1:0] prod_s;
    logic signed [PROD_W-1:0] aligned;
    logic [PROD_W-FULL_W:0]   top_bits;
    logic                     fits;
    logic [FULL_W-1:0]        u_max, s_max, s_min;
    logic [FULL_W-1:0]        prod_lim;
    logic [FULL_W:0]          sum;
    logic                     add_ovf;

    always_comb begin
        u_max  = '1;
        s_max  = {1'b0, {(FULL_W-1){1'b1}}};
        s_min  = {1'b1, {(FULL_W-1){1'b0}}};
        prod_s = $signed(product_i);
        aligned = is_frac_i ? (prod_s >>> (HALF_W - 1)) : prod_s;
        top_bits = aligned[PROD_W-1:FULL_W-1];
        if (is_signed_i) begin
            fits = (&top_bits) || !(|top_bits);
        end else begin
            fits = !(|top_bits[PROD_W-FULL_W:1]);
        end
        ovf_mul_o = !fits;

        if (!fits && sat_i) begin
            if (is_signed_i) begin
                prod_lim = aligned[PROD_W-1] ? s_min : s_max;
            end else begin
                prod_lim = u_max;
            end
        end else begin
            prod_lim = aligned[FULL_W-1:0];
        end

        sum = {is_signed_i & prod_lim[FULL_W-1], prod_lim}
            + {is_signed_i & addend_i[FULL_W-1], addend_i};
        add_ovf = is_signed_i ? (sum[FULL_W] ^ sum[FULL_W-1]) : sum[FULL_W];

        if (!add_en_i) begin
            result_o  = prod_lim;
            ovf_add_o = 1'b0;
        end else if (add_ovf && sat_i) begin
            result_o  = is_signed_i ? (sum[FULL_W] ? s_min : s_max) : u_max;
            ovf_add_o = 1'b1;
        end else begin
            result_o  = sum[FULL_W-1:0];
            ovf_add_o = add_ovf;
        end
        neg_o = is_signed_i & result_o[FULL_W-1];
    end
endmodule

// File: rtl/fmac_unit.sv
module fmac_unit
    import fmac_pkg::*;
#(
    parameter int unsigned HALF_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [1:0]           fmt_i,
    input  logic [2:0]           form_i,
    input  logic                 sat_i,
    input  logic [2*HALF_W-1:0]  op_a_i,
    input  logic [HALF_W-1:0]    op_b_i,
    input  logic                 clr_flags_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [2*HALF_W-1:0]  acc_o,
    output logic                 flag_v_o,
    output logic                 flag_q_o,
    output logic                 flag_n_o
);
    localparam int unsigned FULL_W = 2 * HALF_W;
    localparam int unsigned PROD_W = 3 * HALF_W + 2;

    typedef struct packed {
        state_e            state;
        logic [FULL_W-1:0] addend;
        logic              add_en;
        logic              is_signed;
        logic              is_frac;
        logic              sat;
        logic [FULL_W-1:0] acc;
        logic              v;
        logic              q;
        logic              n;
        logic              done;
    } unit_t;

    unit_t st_d, st_q;

    logic [FULL_W-1:0] sel_mcand, sel_addend;
    logic              sel_add_en, sel_signed, sel_frac;
    logic              accept, fin_now;
    logic [PROD_W-1:0] product;
    logic [FULL_W-1:0] fin_result;
    logic              fin_v, fin_q, fin_n;

    assign accept  = start_i && (st_q.state == ST_IDLE);
    assign fin_now = (st_q.state == ST_FIN);

    fmac_opsel #(.HALF_W(HALF_W)) u_opsel (
        .fmt_i       (fmt_i),
        .form_i      (form_i),
        .op_a_i      (op_a_i),
        .acc_i       (st_q.acc),
        .mcand_o     (sel_mcand),
        .addend_o    (sel_addend),
        .add_en_o    (sel_add_en),
        .is_signed_o (sel_signed),
        .is_frac_o   (sel_frac)
    );

    fmac_mul_iter #(.HALF_W(HALF_W)) u_mul (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .mcand_i     (sel_mcand),
        .is_signed_i (sel_signed),
        .mult_i      (op_b_i),
        .step_lo_i   (st_q.state == ST_LO),
        .step_hi_i   (st_q.state == ST_HI),
        .product_o   (product)
    );

    fmac_finish #(.HALF_W(HALF_W)) u_fin (
        .product_i   (product),
        .is_signed_i (st_q.is_signed),
        .is_frac_i   (st_q.is_frac),
        .sat_i       (st_q.sat),
        .add_en_i    (st_q.add_en),
        .addend_i    (st_q.addend),
        .result_o    (fin_result),
        .ovf_mul_o   (fin_v),
        .ovf_add_o   (fin_q),
        .neg_o       (fin_n)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.v    = st_q.v & ~clr_flags_i;
        st_d.q    = st_q.q & ~clr_flags_i;
        case (st_q.state)
            ST_IDLE: begin
                if (accept) begin
                    st_d.state     = ST_LO;
                    st_d.addend    = sel_addend;
                    st_d.add_en    = sel_add_en;
                    st_d.is_signed = sel_signed;
                    st_d.is_frac   = sel_frac;
                    st_d.sat       = sat_i;
                end
            end
            ST_LO:   st_d.state = ST_HI;
            ST_HI:   st_d.state = ST_FIN;
            default: begin
                st_d.state = ST_IDLE;
                st_d.acc   = fin_result;
                // a new event wins over a clear in the same cycle
                st_d.v     = st_d.v | fin_v;
                st_d.q     = st_d.q | fin_q;
                st_d.n     = fin_n;
                st_d.done  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = (st_q.state != ST_IDLE);
    assign done_o   = st_q.done;
    assign acc_o    = st_q.acc;
    assign flag_v_o = st_q.v;
    assign flag_q_o = st_q.q;
    assign flag_n_o = st_q.n;
endmodule

// File: rtl/fmac_unit_chk.sv
module fmac_unit_chk #(
    parameter int unsigned FULL_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              clr_flags_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [FULL_W-1:0] acc_o,
    input logic              flag_v_o,
    input logic              flag_q_o,
    input logic              fin_now
);
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |-> ##4 done_o);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_acc_only_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_o) |-> done_o);

    assert_sticky_v_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_v_o && !clr_flags_i) |=> flag_v_o);

    assert_sticky_q_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q_o && !clr_flags_i) |=> flag_q_o);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flags_i && !fin_now) |=> (!flag_v_o && !flag_q_o));
endmodule

bind fmac_unit fmac_unit_chk #(.FULL_W(2*HALF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .clr_flags_i (clr_flags_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .acc_o       (acc_o),
    .flag_v_o    (flag_v_o),
    .flag_q_o    (flag_q_o),
    .fin_now     (fin_now)
);

// File: tb/fmac_unit_tb.sv
module fmac_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  fmt_i = '0;
    logic [2:0]  form_i = '0;
    logic        sat_i = 1'b0;
    logic [63:0] op_a_i = '0;
    logic [31:0] op_b_i = '0;
    logic        clr_flags_i = 1'b0;
    logic        busy_o, done_o, flag_v_o, flag_q_o, flag_n_o;
    logic [63:0] acc_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [63:0] e_acc = '0;
    logic        e_v = 1'b0, e_q = 1'b0, e_n = 1'b0;

    always #10 clk = ~clk;

    fmac_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fmt_i(fmt_i),
        .form_i(form_i), .sat_i(sat_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
        .clr_flags_i(clr_flags_i), .busy_o(busy_o), .done_o(done_o),
        .acc_o(acc_o), .flag_v_o(flag_v_o), .flag_q_o(flag_q_o),
        .flag_n_o(flag_n_o)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference: {result, v, q, n}
    function automatic logic [66:0] ref_op(input logic [1:0] fm, input logic [2:0] fo,
                                           input logic st, input logic [63:0] a,
                                           input logic [31:0] b, input logic [63:0] acc);
        logic signed [127:0] m, bb, e, s, smax, smin, umax;
        logic [63:0] m64, pv, addv, r;
        logic sg, fr, v, q, fits;
        sg = (fm != 2'd0);
        fr = (fm == 2'd2);
        smax = {64'd0, 64'h7FFF_FFFF_FFFF_FFFF};
        smin = -smax - 128'sd1;
        umax = {64'd0, {64{1'b1}}};
        case (fo % 3)
            0: m64 = fr ? {a[31:0], 32'd0} : (sg ? {{32{a[31]}}, a[31:0]} : {32'd0, a[31:0]});
            1: m64 = a;
            default: m64 = acc;
        endcase
        m  = sg ? {{64{m64[63]}}, m64} : {64'd0, m64};
        bb = sg ? {{96{b[31]}}, b} : {96'd0, b};
        e = m * bb;
        if (fr) e = e >>> 31;
        fits = sg ? (e <= smax && e >= smin) : (e <= umax);
        v = !fits;
        if (fits || !st) pv = e[63:0];
        else pv = sg ? (e < 0 ? smin[63:0] : smax[63:0]) : umax[63:0];
        q = 1'b0;
        r = pv;
        if (fo >= 3) begin
            addv = (fo == 3'd5) ? a : acc;
            s = (sg ? {{64{pv[63]}}, pv} : {64'd0, pv}) +
                (sg ? {{64{addv[63]}}, addv} : {64'd0, addv});
            fits = sg ? (s <= smax && s >= smin) : (s <= umax);
            q = !fits;
            if (fits || !st) r = s[63:0];
            else r = sg ? (s < 0 ? smin[63:0] : smax[63:0]) : umax[63:0];
        end
        return {r, v, q, sg & r[63]};
    endfunction

    // poke: hold start with other operands while busy; clr_fin: clear at completing edge
    task automatic run_op(input logic [1:0] fm, input logic [2:0] fo, input logic st,
                          input logic [63:0] a, input logic [31:0] b,
                          input bit poke, input bit clr_fin, input string tag);
        logic [66:0] r;
        int cnt;
        r = ref_op(fm, fo, st, a, b, e_acc);
        @(negedge clk);
        fmt_i = fm; form_i = fo; sat_i = st; op_a_i = a; op_b_i = b; start_i = 1'b1;
        @(negedge clk);
        if (poke) begin
            fmt_i = fm + 2'd1; form_i = 3'd2; sat_i = ~st;
            op_a_i = ~a; op_b_i = ~b;
        end else begin
            start_i = 1'b0;
        end
        cnt = 0;
        while (!done_o && cnt < 20) begin
            @(negedge clk);
            cnt++;
            if (cnt == 2) begin
                start_i = 1'b0;
                if (clr_fin) clr_flags_i = 1'b1;
            end
            if (cnt == 3) clr_flags_i = 1'b0;
        end
        clr_flags_i = 1'b0;
        e_v   = (e_v & ~clr_fin) | r[2];
        e_q   = (e_q & ~clr_fin) | r[1];
        e_n   = r[0];
        e_acc = r[66:3];
        check(cnt == 3, {"R8 latency ", tag}, 64'(cnt), 64'd3);
        check(acc_o == e_acc, {"R2 acc ", tag}, acc_o, e_acc);
        check({flag_v_o, flag_q_o, flag_n_o} == {e_v, e_q, e_n}, {"R3 R5 R6 flags ", tag},
              {61'd0, flag_v_o, flag_q_o, flag_n_o}, {61'd0, e_v, e_q, e_n});
        @(negedge clk);
        check(!done_o && !busy_o, {"R8 R9 done pulse and no queued job ", tag},
              {62'd0, done_o, busy_o}, 64'd0);
    endtask

    task automatic load_acc(input logic [63:0] v);
        run_op(2'd0, 3'd1, 1'b0, v, 32'd1, 1'b0, 1'b0, "load");
    endtask

    task automatic clear_flags();
        @(negedge clk);
        clr_flags_i = 1'b1;
        @(negedge clk);
        clr_flags_i = 1'b0;
        e_v = 1'b0; e_q = 1'b0;
        check(!flag_v_o && !flag_q_o, "R7 clear", {62'd0, flag_v_o, flag_q_o}, 64'd0);
    endtask

    function automatic logic [63:0] rnd64();
        case ($urandom % 7)
            0: return 64'd0;
            1: return {64{1'b1}};
            2: return 64'h8000_0000_0000_0000;
            3: return 64'h7FFF_FFFF_FFFF_FFFF;
            4: return {32'd0, 32'h8000_0000};
            5: return 64'($urandom % 16);
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check(acc_o == 64'd0 && !flag_v_o && !flag_q_o && !flag_n_o && !done_o && !busy_o,
              "R1 reset", acc_o, 64'd0);
        rst_n = 1'b1;

        // R4 fraction -1 * -1
        run_op(2'd2, 3'd0, 1'b1, 64'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, "R4 frac sat");
        check(acc_o == 64'h7FFF_FFFF_FFFF_FFFF, "R4 frac sat value", acc_o, 64'h7FFF_FFFF_FFFF_FFFF);
        clear_flags();
        run_op(2'd2, 3'd0, 1'b0, 64'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, "R4 frac wrap");
        check(acc_o == 64'h8000_0000_0000_0000, "R4 frac wrap value", acc_o, 64'h8000_0000_0000_0000);
        clear_flags();
        // R4 half * half = quarter
        run_op(2'd2, 3'd0, 1'b0, 64'h4000_0000, 32'h4000_0000, 1'b0, 1'b0, "R4 frac half");
        check(acc_o == 64'h2000_0000_0000_0000, "R4 frac half value", acc_o, 64'h2000_0000_0000_0000);

        // R3 unsigned product overflow, saturating
        load_acc(64'hFFFF_FFFF_FFFF_FFFF);
        run_op(2'd0, 3'd2, 1'b1, 64'd0, 32'd2, 1'b0, 1'b0, "R3 uns sat");
        check(flag_v_o && acc_o == {64{1'b1}}, "R3 uns sat value", acc_o, {64{1'b1}});
        clear_flags();

        // R5 unsigned accumulate carry, saturating
        load_acc(64'hFFFF_FFFF_FFFF_FFF0);
        run_op(2'd0, 3'd3, 1'b1, 64'd5, 32'd5, 1'b0, 1'b0, "R5 uns mac sat");
        check(flag_q_o && !flag_v_o, "R5 Q set", {62'd0, flag_q_o, flag_v_o}, 64'd2);
        clear_flags();

        // R5 signed accumulate overflow, wrapping, form 5
        load_acc(64'h7FFF_FFFF_FFFF_FFFF);
        run_op(2'd1, 3'd5, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 32'd1, 1'b0, 1'b0, "R5 sgn maca wrap");
        check(acc_o == 64'hFFFF_FFFF_FFFF_FFFE && flag_n_o, "R6 negative after wrap",
              acc_o, 64'hFFFF_FFFF_FFFF_FFFE);

        // R6 unsigned result with top bit set keeps N at 0
        run_op(2'd0, 3'd1, 1'b0, 64'h8000_0000_0000_0001, 32'd1, 1'b0, 1'b0, "R6 uns N");
        check(!flag_n_o, "R6 unsigned N zero", {63'd0, flag_n_o}, 64'd0);

        // R7 coincident clear: overflowing job keeps V, clean job clears it
        clear_flags();
        run_op(2'd2, 3'd0, 1'b1, 64'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, "R7 clr with ovf");
        check(flag_v_o, "R7 set wins", {63'd0, flag_v_o}, 64'd1);
        run_op(2'd1, 3'd0, 1'b0, 64'd3, 32'd4, 1'b0, 1'b1, "R7 clr no ovf");
        check(!flag_v_o, "R7 clear at completion", {63'd0, flag_v_o}, 64'd0);

        // R9 start while busy ignored
        run_op(2'd1, 3'd4, 1'b0, 64'd1000, 32'hFFFF_FFFF, 1'b1, 1'b0, "R9 poke");

        // R2 random mix of all formats, shapes and variants
        for (int i = 0; i < 400; i++) begin
            logic [1:0] fm;
            logic [2:0] fo;
            fm = 2'($urandom % 3);
            fo = 3'($urandom % 6);
            if (i % 50 == 0) clear_flags();
            run_op(fm, fo, 1'($urandom % 2), rnd64(),
                   (($urandom % 3) == 0) ? rnd64() >> 32 : $urandom,
                   (i % 37) == 0, (i % 23) == 0, "R2 random");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule